// File: doc/BRIEF.md
# Gain Change Sequencer

The sequencer sits in front of one channel's gain stage and decides when, and by how much, the applied gain code follows a newly requested code. Gain codes are unsigned and one code is half a decibel. Work is paced by a frame strobe that arrives once per audio sample period. The same strobe qualifies a signed sample that is watched for zero crossings. Each channel has its own instance and its own pair of mode bits.

With both modes off, a request is taken in one jump. Soft ramp moves the applied code one step at a time, with one step every sixteen frames. Zero-cross mode holds each change until the watched signal crosses zero. If no crossing comes within 1024 frames, the change goes through anyway. With both modes on, every single ramp step waits for its own crossing or timeout. A request that changes while a move is under way redirects the move from the code presently applied.

Top module: `vol_slew_seq`

## Requirements
- R1: While `rst_n` is low, `gain_out` equals the RESET_GAIN parameter (32 by default), the pacing and timeout counts are zero, and the remembered sign of the previous sample is non-negative. The reset acts asynchronously.
- R2: With `ramp_en` and `zc_en` both low, a differing `target_gain` is copied to `gain_out` at the first frame strobe.
- R3: With `ramp_en` high and `zc_en` low, `gain_out` moves exactly one code toward the target on the 16th frame strobe after the difference appeared, or after the previous step. No other strobe changes it.
- R4: With `zc_en` high, a change happens only on a frame strobe whose sample is a zero crossing. A crossing is a sample equal to zero, or a sample whose sign bit (the MSB, two's complement) differs from that of the sample on the previous strobe.
- R5: With `zc_en` high and no crossing, the pending change is applied on the 1024th frame strobe counted from when the wait began.
- R6: With both modes high, the wait for a crossing starts once a step's 16-frame pacing has run out. The timeout count restarts for every step.
- R7: A new target that arrives while a change is pending redirects the movement from the present `gain_out`. While codes still differ, the pacing count is not restarted, so no step is lost or repeated.
- R8: `gain_out` never passes the target and never moves away from it. `done` is high exactly while `gain_out` equals `target_gain`, and it responds within the same cycle.
- R9: `gain_out` changes only on clock edges where `frame_stb` is high, apart from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per sample period; qualifies `sample_in` |
| sample_in | input | SAMP_W | Signed sample watched for zero crossings |
| target_gain | input | GAIN_W | Requested gain code, half-dB units |
| ramp_en | input | 1 | Soft ramp mode |
| zc_en | input | 1 | Zero-cross mode |
| gain_out | output | GAIN_W | Applied gain code for the gain stage |
| done | output | 1 | High while the applied code equals the request |

## Verification
A pacing count that is off by one shows up at the ports within the first ramp step, because the code changes on the 15th or 17th strobe instead of the 16th. The bench samples the strobe on either side of that edge. A timeout count that is not cleared between steps is caught by a two-step ramp with zero-cross mode: its second step must wait a full 1024 frames after pacing, so a stale count moves the code hundreds of frames too early. A zero-crossing memory that tracks the wrong sample moves the code one strobe early or late, and that is seen at once.

// File: rtl/vss_pkg.sv
package vss_pkg;

  // Direction the applied gain must travel to reach the request.
  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2
  } move_e;

endpackage

// File: rtl/vss_frame_ctr.sv
// Saturating frame counter: counts qualified strobes up to LIMIT-1 and
// holds there until cleared. at_limit is a level.
module vss_frame_ctr #(
  parameter  int LIMIT = 16,
  localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic at_limit
);

  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_ce = (cnt_q != '0);
      cnt_d  = '0;
    end else if (count_en && (cnt_q != LAST)) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/vss_zero_cross.sv
// Flags a strobe whose sample is zero or whose sign differs from the
// sample seen on the previous strobe.
module vss_zero_cross #(
  parameter int SAMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SAMP_W-1:0] sample_in,
  output logic              zc_hit
);

  logic prev_neg_q;
  logic prev_neg_d;
  logic cur_neg;
  logic cur_zero;

  assign cur_neg  = sample_in[SAMP_W-1];
  assign cur_zero = (sample_in == '0);

  always_comb begin
    prev_neg_d = prev_neg_q;
    if (frame_stb) begin
      prev_neg_d = cur_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_neg_q <= 1'b0;
    end else if (frame_stb) begin
      prev_neg_q <= prev_neg_d;
    end
  end

  assign zc_hit = frame_stb && (cur_zero || (cur_neg != prev_neg_q));

endmodule

// File: rtl/vss_step_calc.sv
// Compares the applied code with the request and gives the direction.
module vss_step_calc
  import vss_pkg::*;
#(
  parameter int GAIN_W = 8
) (
  input  logic [GAIN_W-1:0] cur_gain,
  input  logic [GAIN_W-1:0] req_gain,
  output logic              pending,
  output move_e             dir
);

  always_comb begin
    pending = (cur_gain != req_gain);
    if (cur_gain < req_gain) begin
      dir = MOVE_UP;
    end else if (cur_gain > req_gain) begin
      dir = MOVE_DOWN;
    end else begin
      dir = MOVE_HOLD;
    end
  end

endmodule

// File: rtl/vol_slew_seq.sv
// Per-channel gain change sequencer: immediate, ramped, zero-cross gated
// or both, with a frame-count timeout on the zero-cross wait.
module vol_slew_seq
  import vss_pkg::*;
#(
  parameter int              GAIN_W      = 8,
  parameter int              SAMP_W      = 16,
  parameter int              STEP_FRAMES = 16,
  parameter int              ZC_TIMEOUT  = 1024,
  parameter logic [GAIN_W-1:0] RESET_GAIN = GAIN_W'(32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SAMP_W-1:0] sample_in,
  input  logic [GAIN_W-1:0] target_gain,
  input  logic              ramp_en,
  input  logic              zc_en,
  output logic [GAIN_W-1:0] gain_out,
  output logic              done
);

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_d;
  logic              pending;
  move_e             dir;
  logic              zc_hit;
  logic              pace_ready;
  logic              pace_clear;
  logic              pace_count;
  logic              tmo_limit;
  logic              tmo_clear;
  logic              tmo_count;
  logic              tmo_hit;
  logic              gate_pace;
  logic              gate_zc;
  logic              zc_armed;
  logic              step_go;

  vss_step_calc #(.GAIN_W(GAIN_W)) u_calc (
    .cur_gain (gain_q),
    .req_gain (target_gain),
    .pending  (pending),
    .dir      (dir)
  );

  vss_zero_cross #(.SAMP_W(SAMP_W)) u_zc (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .sample_in (sample_in),
    .zc_hit    (zc_hit)
  );

  // Ramp pacing: counts strobes while a ramped change is pending; the count
  // survives a target change and is dropped once the codes agree.
  assign pace_clear = !pending || !ramp_en || step_go;
  assign pace_count = frame_stb;

  vss_frame_ctr #(.LIMIT(STEP_FRAMES)) u_pace (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pace_clear),
    .count_en (pace_count),
    .at_limit (pace_ready)
  );

  assign gate_pace = !ramp_en || pace_ready;

  // Zero-cross wait is armed only once pacing allows a change, so each
  // ramp step gets a fresh timeout window.
  assign zc_armed  = pending && zc_en && gate_pace;
  assign tmo_clear = !zc_armed || step_go;
  assign tmo_count = frame_stb;

  vss_frame_ctr #(.LIMIT(ZC_TIMEOUT)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tmo_clear),
    .count_en (tmo_count),
    .at_limit (tmo_limit)
  );

  assign tmo_hit = frame_stb && tmo_limit;
  assign gate_zc = !zc_en || zc_hit || tmo_hit;
  assign step_go = frame_stb && pending && gate_pace && gate_zc;

  always_comb begin
    gain_d = gain_q;
    if (step_go) begin
      if (!ramp_en) begin
        gain_d = target_gain;
      end else begin
        case (dir)
          MOVE_UP:   gain_d = gain_q + 1'b1;
          MOVE_DOWN: gain_d = gain_q - 1'b1;
          default:   gain_d = gain_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= RESET_GAIN;
    end else if (step_go) begin
      gain_q <= gain_d;
    end
  end

  assign gain_out = gain_q;
  assign done     = !pending;

endmodule

// File: rtl/vss_checker.sv
module vss_checker #(
  parameter int GAIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              ramp_en,
  input logic              zc_en,
  input logic [GAIN_W-1:0] target_gain,
  input logic [GAIN_W-1:0] gain_out
);

  // R9: no movement without a frame strobe
  a_r9_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(gain_out));

  // R3: a ramped change moves by at most one code per edge
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |=> (gain_out == $past(gain_out)) ||
                (gain_out == $past(gain_out) + 1'b1) ||
                (gain_out == $past(gain_out) - 1'b1));

  // R8: rising toward the target never passes it
  a_r8_no_overshoot_up: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_out < target_gain) |=>
      (gain_out >= $past(gain_out)) && (gain_out <= $past(target_gain)));

  // R8: falling toward the target never passes it
  a_r8_no_overshoot_down: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_out > target_gain) |=>
      (gain_out <= $past(gain_out)) && (gain_out >= $past(target_gain)));

  // R2: immediate mode lands on the request at the strobe
  a_r2_direct_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !ramp_en && !zc_en) |=> (gain_out == $past(target_gain)));

endmodule

bind vol_slew_seq vss_checker #(.GAIN_W(GAIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_stb   (frame_stb),
  .ramp_en     (ramp_en),
  .zc_en       (zc_en),
  .target_gain (target_gain),
  .gain_out    (gain_out)
);

// File: tb/sim_vol_slew_seq.sv
`timescale 1ns/1ps
module sim_vol_slew_seq;

  logic        clk;
  logic        rst_n;
  logic        frame_stb;
  logic [15:0] sample_in;
  logic [7:0]  target_gain;
  logic        ramp_en;
  logic        zc_en;
  logic [7:0]  gain_out;
  logic        done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  vol_slew_seq u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sample_in(sample_in),
    .target_gain(target_gain), .ramp_en(ramp_en), .zc_en(zc_en),
    .gain_out(gain_out), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        ramp;
    logic        zc;
    logic [7:0]  tgt;
    logic [15:0] nstb;
    logic [7:0]  expv;
  } vec_t;

  // Walked in order; each row starts from the previous row's end state.
  // Samples stay at +100, so no zero crossing occurs in the table.
  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b0, 8'd50, 16'd1,    8'd50},  // R2 jump up
    '{1'b0, 1'b0, 8'd10, 16'd1,    8'd10},  // R2 jump down
    '{1'b1, 1'b0, 8'd13, 16'd16,   8'd11},  // R3 first step on 16th
    '{1'b1, 1'b0, 8'd13, 16'd15,   8'd11},  // R3 none on 15th
    '{1'b1, 1'b0, 8'd13, 16'd1,    8'd12},  // R3 step on 16th
    '{1'b1, 1'b0, 8'd13, 16'd16,   8'd13},  // R3 reach target
    '{1'b1, 1'b0, 8'd11, 16'd32,   8'd11},  // R3 two steps down
    '{1'b1, 1'b0, 8'd11, 16'd5,    8'd11},  // R8 rests at target
    '{1'b0, 1'b1, 8'd40, 16'd1023, 8'd11},  // R5 still waiting
    '{1'b0, 1'b1, 8'd40, 16'd1,    8'd40}   // R5 timeout applies
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_stb = 1'b1;
      sample_in = s;
      @(negedge clk);
      frame_stb = 1'b0;
    end
  endtask

  task automatic setup(input logic r, input logic z, input logic [7:0] t);
    @(negedge clk);
    ramp_en     = r;
    zc_en       = z;
    target_gain = t;
    #1;
  endtask

  localparam logic [15:0] POS = 16'sd100;
  localparam logic [15:0] NEG = -16'sd100;

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; sample_in = POS;
    target_gain = 8'd32; ramp_en = 1'b0; zc_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset gain", gain_out, 32);
    chk("R8 done at reset", done, 1);
    rst_n = 1'b1;

    for (int k = 0; k < 10; k++) begin
      setup(VECS[k].ramp, VECS[k].zc, VECS[k].tgt);
      strobe(POS, int'(VECS[k].nstb));
      chk($sformatf("R2/R3/R5 row %0d gain", k), gain_out, VECS[k].expv);
      chk($sformatf("R8 row %0d done", k), done, (VECS[k].expv == VECS[k].tgt) ? 1 : 0);
    end

    // R4: crossings gate the change
    setup(1'b0, 1'b1, 8'd60);
    strobe(POS, 3);
    chk("R4 no crossing holds", gain_out, 40);
    strobe(-16'sd5, 1);
    chk("R4 sign change applies", gain_out, 60);
    setup(1'b0, 1'b1, 8'd70);
    strobe(-16'sd7, 2);
    chk("R4 same sign holds", gain_out, 60);
    strobe(16'd0, 1);
    chk("R4 zero sample applies", gain_out, 70);

    // R6: both modes, timeout restarts per step
    setup(1'b1, 1'b1, 8'd72);
    strobe(POS, 16);
    chk("R6 paced but no crossing", gain_out, 70);
    strobe(NEG, 1);
    chk("R6 crossing takes step", gain_out, 71);
    strobe(NEG, 1038);
    chk("R6 fresh timeout not yet", gain_out, 71);
    strobe(NEG, 1);
    chk("R6 fresh timeout applies", gain_out, 72);

    // R7: redirect mid-ramp
    setup(1'b1, 1'b0, 8'd80);
    strobe(POS, 16);
    chk("R7 first step up", gain_out, 73);
    strobe(POS, 8);
    setup(1'b1, 1'b0, 8'd60);
    strobe(POS, 7);
    chk("R7 count kept, no step yet", gain_out, 73);
    strobe(POS, 1);
    chk("R7 step down from present", gain_out, 72);
    setup(1'b1, 1'b0, 8'd72);
    chk("R8 done on matching request", done, 1);
    strobe(NEG, 20);
    chk("R8 no move at target", gain_out, 72);

    // R9: no change without strobe
    setup(1'b0, 1'b0, 8'd5);
    repeat (10) @(negedge clk);
    chk("R9 no strobe no change", gain_out, 72);
    strobe(POS, 1);
    chk("R2 applies at strobe", gain_out, 5);

    // R1: asynchronous reset mid-ramp clears pacing
    setup(1'b1, 1'b0, 8'd90);
    strobe(POS, 9);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset gain", gain_out, 32);
    @(negedge clk);
    rst_n = 1'b1;
    setup(1'b1, 1'b0, 8'd34);
    strobe(POS, 15);
    chk("R1 pacing restarted", gain_out, 32);
    strobe(POS, 1);
    chk("R1 step on 16th after reset", gain_out, 33);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule